// File: doc/BRIEF.md
# Pulse-Driven Exposure Sequencer

This block runs a frame-transfer image sensor in an externally timed exposure mode. When the mode input is high, an active-low trigger pin controls the exposure. A debounced falling edge on the pin issues two flush transfers, which empty the sensor. Integration follows and lasts as long as the pin stays low. The debounced rising edge issues the readout transfer. In the same cycle it pulses a preload request, so the vertical video counter jumps to a fixed line of the odd field and the exposed field is sent out at once. Exactly one field is output per exposure. After that field the block returns to idle. In idle, the enables keep running but the video is blanked.

The block produces the transfer strobes and the gating for the surrounding timing generator. It does not generate sync, pixel clocks or video counters itself. The exposure length is the low width of the trigger pulse less the fixed flush time. The block enforces no lower or upper limit on it. A release that arrives before the flush has finished cancels the integration. The readout is still issued, and an error pulse marks that the exposure was cancelled.

Top module: `pdi_exposure_seq`

## Requirements
- R1: Out of reset with the mode input low, `enable_gate_o` is 1, `video_black_o` is 0, `preset_line_o` is 0, and all strobes and `integrating_o` are 0.
- R2: While `mode_en_i` is low, trigger activity produces no flush, readout or integration. In that state `enable_gate_o` stays 1 and `video_black_o` stays 0.
- R3: In mode with no exposure in progress, `video_black_o` is 1, `enable_gate_o` is 1 and `integrating_o` is 0.
- R4: A debounced falling trigger edge produces exactly two one-cycle `flush_o` pulses, FLUSH_HALF cycles apart. `enable_gate_o` is 0 from the first pulse until the readout.
- R5: `integrating_o` rises 2*FLUSH_HALF cycles after the first flush pulse and stays high until the rising edge is seen. It is high for exactly (low width − 2*FLUSH_HALF) cycles, so a width of 2*FLUSH_HALF+1 gives one cycle.
- R6: The seen rising edge produces one `readout_o` pulse. `vload_o` pulses in the same cycle, while `preset_line_o` carries PRESET_LINE (default 6). `preset_line_o` is 0 in every other cycle.
- R7: While `integrating_o` is 1, `enable_gate_o` is 0 and `video_black_o` is 1.
- R8: After the readout, `video_black_o` is 0 for exactly FIELD_CYCLES cycles. Then the block returns to the R3 idle state.
- R9: A rising edge seen while flushing (low width ≤ 2*FLUSH_HALF) still produces the readout. `cancel_o` pulses in the same cycle, and `integrating_o` never rises.
- R10: A falling edge that arrives while the output field is still running is ignored, so no new flush is issued.
- R11: A low pulse of fewer than DEBOUNCE cycles on the trigger pin is ignored.
- R12: Dropping `mode_en_i` in mid-exposure abandons the sequence without a readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en_i | input | 1 | Selects the pulse-driven exposure mode |
| trig_n_i | input | 1 | External active-low exposure trigger, asynchronous |
| flush_o | output | 1 | One-cycle sensor flush transfer strobe |
| readout_o | output | 1 | One-cycle readout transfer strobe |
| vload_o | output | 1 | Vertical counter preload pulse |
| preset_line_o | output | LINE_W | Line to load, valid with `vload_o`, else 0 |
| integrating_o | output | 1 | High while the sensor integrates |
| cancel_o | output | 1 | Pulses with a readout that cut the flush short |
| enable_gate_o | output | 1 | 1 lets frame/line enables through |
| video_black_o | output | 1 | 1 forces the video output black |

## Verification
A state register stuck in the wrong value shows at the gating outputs in the cycle after the fault. An exposure that never ends holds `enable_gate_o` low, and a missed return to idle leaves `video_black_o` low longer than FIELD_CYCLES. An off-by-one in the flush or field timer changes the integration count or the length of the unblanked window by exactly one cycle. The bench therefore counts these cycles exactly, rather than against a tolerance. A wrong edge decision, such as a re-arm during the output field or acting on a glitch, appears as an extra flush pulse within a few cycles of the trigger change.

// File: rtl/pdi_pkg.sv
package pdi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_INTEG = 2'd2,
    ST_READ  = 2'd3
  } pdi_state_t;
endpackage

// File: rtl/pdi_pin_cond.sv
module pdi_pin_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int DEBOUNCE    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic start_o,
  output logic stop_o
);
  localparam int CW = $clog2(DEBOUNCE + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   act_q, act_d, act_n;
  logic [CW-1:0]          cnt_q, cnt_n;
  logic                   lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
  end

  assign lvl = ~sync_q[SYNC_STAGES-1];

  always_comb begin
    act_n = act_q;
    cnt_n = '0;
    if (lvl != act_q) begin
      if (cnt_q == CNT_LAST) act_n = lvl;
      else                   cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      act_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_n;
      act_d <= act_q;
      cnt_q <= cnt_n;
    end
  end

  assign start_o = act_q & ~act_d;
  assign stop_o  = ~act_q & act_d;
endmodule

// File: rtl/pdi_seq_fsm.sv
module pdi_seq_fsm
  import pdi_pkg::*;
#(
  parameter int FLUSH_HALF   = 16,
  parameter int FIELD_CYCLES = 200,
  parameter int TW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          stop_i,
  output pdi_state_t    state_o,
  output logic [TW-1:0] tmr_o,
  output logic          early_o
);
  localparam logic [TW-1:0] FLUSH_LAST = TW'(2 * FLUSH_HALF - 1);
  localparam logic [TW-1:0] FIELD_LAST = TW'(FIELD_CYCLES - 1);

  pdi_state_t    st_q, st_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic          early_q, early_n;

  always_comb begin
    st_n    = st_q;
    tmr_n   = tmr_q + 1'b1;
    early_n = early_q;
    if (!en_i) begin
      st_n  = ST_IDLE;
      tmr_n = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          tmr_n = '0;
          if (start_i) begin
            st_n    = ST_FLUSH;
            early_n = 1'b0;
          end
        end
        ST_FLUSH: begin
          if (stop_i) begin
            st_n    = ST_READ;
            tmr_n   = '0;
            early_n = 1'b1;
          end else if (tmr_q == FLUSH_LAST) begin
            st_n  = ST_INTEG;
            tmr_n = '0;
          end
        end
        ST_INTEG: begin
          tmr_n = '0;
          if (stop_i) st_n = ST_READ;
        end
        ST_READ: begin
          if (tmr_q == FIELD_LAST) begin
            st_n  = ST_IDLE;
            tmr_n = '0;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      early_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      tmr_q   <= tmr_n;
      early_q <= early_n;
    end
  end

  assign state_o = st_q;
  assign tmr_o   = tmr_q;
  assign early_o = early_q;
endmodule

// File: rtl/pdi_exposure_seq.sv
module pdi_exposure_seq
  import pdi_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DEBOUNCE     = 4,
  parameter int FLUSH_HALF   = 16,
  parameter int FIELD_CYCLES = 200,
  parameter int LINE_W       = 10,
  parameter int PRESET_LINE  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en_i,
  input  logic              trig_n_i,
  output logic              flush_o,
  output logic              readout_o,
  output logic              vload_o,
  output logic [LINE_W-1:0] preset_line_o,
  output logic              integrating_o,
  output logic              cancel_o,
  output logic              enable_gate_o,
  output logic              video_black_o
);
  localparam int TMAX = (2 * FLUSH_HALF > FIELD_CYCLES) ? 2 * FLUSH_HALF : FIELD_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0]     SECOND_FLUSH = TW'(FLUSH_HALF);
  localparam logic [LINE_W-1:0] LOAD_LINE    = LINE_W'(PRESET_LINE);

  logic          start_p, stop_p, early;
  pdi_state_t    st;
  logic [TW-1:0] tmr;
  logic          in_seq;

  pdi_pin_cond #(.SYNC_STAGES(SYNC_STAGES), .DEBOUNCE(DEBOUNCE)) u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n_i (trig_n_i),
    .start_o (start_p),
    .stop_o  (stop_p)
  );

  pdi_seq_fsm #(.FLUSH_HALF(FLUSH_HALF), .FIELD_CYCLES(FIELD_CYCLES), .TW(TW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (mode_en_i),
    .start_i (start_p),
    .stop_i  (stop_p),
    .state_o (st),
    .tmr_o   (tmr),
    .early_o (early)
  );

  assign in_seq        = (st == ST_FLUSH) || (st == ST_INTEG);
  assign flush_o       = mode_en_i && (st == ST_FLUSH) && (tmr == '0 || tmr == SECOND_FLUSH);
  assign readout_o     = mode_en_i && (st == ST_READ) && (tmr == '0);
  assign vload_o       = readout_o;
  assign cancel_o      = readout_o && early;
  assign preset_line_o = readout_o ? LOAD_LINE : '0;
  assign integrating_o = mode_en_i && (st == ST_INTEG);
  assign enable_gate_o = !mode_en_i || !in_seq;
  assign video_black_o = mode_en_i && (st != ST_READ);
endmodule

// File: rtl/pdi_exposure_seq_chk.sv
module pdi_exposure_seq_chk #(
  parameter int LINE_W      = 10,
  parameter int PRESET_LINE = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_en_i,
  input logic              flush_o,
  input logic              readout_o,
  input logic              vload_o,
  input logic [LINE_W-1:0] preset_line_o,
  input logic              integrating_o,
  input logic              cancel_o,
  input logic              enable_gate_o,
  input logic              video_black_o
);
  // R6
  a_r6_readout_loads: assert property (@(posedge clk) disable iff (!rst_n)
    readout_o |-> (vload_o && preset_line_o == LINE_W'(PRESET_LINE)));
  // R6
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    readout_o |=> !readout_o);
  // R9
  a_r9_cancel_with_readout: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |-> readout_o);
  // R7
  a_r7_gate_off_integ: assert property (@(posedge clk) disable iff (!rst_n)
    integrating_o |-> (!enable_gate_o && video_black_o));
  // R4
  a_r4_flush_gated: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !enable_gate_o);
  // R5
  a_r5_integ_ends_in_readout: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(integrating_o) && mode_en_i) |-> readout_o);
  // R2
  a_r2_mode_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en_i |=> (!flush_o && !readout_o && !integrating_o));
endmodule

bind pdi_exposure_seq pdi_exposure_seq_chk #(.LINE_W(LINE_W), .PRESET_LINE(PRESET_LINE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_en_i     (mode_en_i),
  .flush_o       (flush_o),
  .readout_o     (readout_o),
  .vload_o       (vload_o),
  .preset_line_o (preset_line_o),
  .integrating_o (integrating_o),
  .cancel_o      (cancel_o),
  .enable_gate_o (enable_gate_o),
  .video_black_o (video_black_o)
);

// File: tb/pdi_exposure_seq_bench.sv
`timescale 1ns/1ps
module pdi_exposure_seq_bench;
  localparam int FH    = 16;
  localparam int FIELD = 200;
  localparam int LW    = 10;

  logic clk = 1'b0;
  logic rst_n, en, trig_n;
  logic flush, rdo, vload, integ, cancel, gate, black;
  logic [LW-1:0] line;

  int n_cmp = 0, n_bad = 0;
  int c_flush, c_rdo, c_cancel, c_integ, c_read, c_gatev, c_linev, c_vmis, c_black, c_gateoff;
  int cyc, f1, f2;
  bit done = 0;

  always #4 clk = ~clk;

  pdi_exposure_seq u_pdi_exposure_seq (
    .clk(clk), .rst_n(rst_n), .mode_en_i(en), .trig_n_i(trig_n),
    .flush_o(flush), .readout_o(rdo), .vload_o(vload), .preset_line_o(line),
    .integrating_o(integ), .cancel_o(cancel), .enable_gate_o(gate), .video_black_o(black)
  );

  task automatic clr();
    c_flush = 0; c_rdo = 0; c_cancel = 0; c_integ = 0; c_read = 0; c_gatev = 0;
    c_linev = 0; c_vmis = 0; c_black = 0; c_gateoff = 0; f1 = -1; f2 = -1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (flush) begin
      c_flush++;
      if (f1 < 0) f1 = cyc; else if (f2 < 0) f2 = cyc;
    end
    if (rdo) c_rdo++;
    if (cancel) c_cancel++;
    if (integ) c_integ++;
    if (en && !black) c_read++;
    if (black) c_black++;
    if (!gate) c_gateoff++;
    if ((integ || flush) && gate) c_gatev++;
    if ((vload && line != LW'(6)) || (!vload && line != '0)) c_linev++;
    if (vload != rdo) c_vmis++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int w);
    trig_n = 1'b0; tick(w); trig_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "gate", gate, 1); chk("R1", "black", black, 0);
    chk("R1", "line", line, 0);
    chk("R1", "strobes", flush | rdo | vload | integ | cancel, 0);
    tick(1); en = 1'b1; tick(3); @(negedge clk);
    chk("R3", "idle black", black, 1); chk("R3", "idle gate", gate, 1);
    chk("R3", "idle integ", integ, 0);
  endtask

  task automatic t_exposure(input int w);
    tick(1); clr(); pulse(w); tick(FIELD + 40); @(negedge clk);
    chk("R4", "flush count", c_flush, 2);
    chk("R4", "flush spacing", f2 - f1, FH);
    chk("R4", "gate off cycles", c_gateoff, w);
    chk("R5", "integ cycles", c_integ, w - 2 * FH);
    chk("R6", "readouts", c_rdo, 1);
    chk("R6", "preset line errs", c_linev, 0);
    chk("R6", "vload mismatch", c_vmis, 0);
    chk("R7", "gate during seq", c_gatev, 0);
    chk("R9", "no cancel", c_cancel, 0);
    chk("R8", "field length", c_read, FIELD);
    chk("R8", "back to black", black, 1);
  endtask

  task automatic t_early(input int w, input int flushes);
    tick(1); clr(); pulse(w); tick(FIELD + 40); @(negedge clk);
    chk("R9", "readouts", c_rdo, 1);
    chk("R9", "cancel", c_cancel, 1);
    chk("R9", "integ cycles", c_integ, 0);
    chk("R9", "flushes", c_flush, flushes);
    chk("R8", "field length", c_read, FIELD);
  endtask

  task automatic t_disabled();
    tick(1); en = 1'b0; tick(2); clr(); pulse(60); tick(60); @(negedge clk);
    chk("R2", "flush", c_flush, 0); chk("R2", "readout", c_rdo, 0);
    chk("R2", "integ", c_integ, 0); chk("R2", "gate off", c_gateoff, 0);
    chk("R2", "black", c_black, 0);
    en = 1'b1; tick(3);
  endtask

  task automatic t_glitch();
    tick(1); clr(); pulse(3); tick(80); @(negedge clk);
    chk("R11", "flush", c_flush, 0); chk("R11", "gate off", c_gateoff, 0);
  endtask

  task automatic t_refire();
    tick(1); clr(); pulse(60); tick(40); pulse(30); tick(FIELD + 60); @(negedge clk);
    chk("R10", "flush", c_flush, 2); chk("R10", "readouts", c_rdo, 1);
    chk("R10", "black", black, 1);
  endtask

  task automatic t_abort();
    tick(1); clr(); trig_n = 1'b0; tick(50); en = 1'b0; tick(5); trig_n = 1'b1;
    tick(20); en = 1'b1; tick(40); @(negedge clk);
    chk("R12", "readouts", c_rdo, 0); chk("R12", "gate", gate, 1);
    chk("R12", "black", black, 1); chk("R12", "flush", c_flush, 2);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; trig_n = 1'b1; cyc = 0; clr();
    tick(4); rst_n = 1'b1;
    t_reset();
    t_exposure(60);
    t_exposure(100);
    t_exposure(2 * FH + 1);
    t_early(10, 1);
    t_early(2 * FH, 2);
    t_disabled();
    t_glitch();
    t_refire();
    t_abort();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule